// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display pipeline: horizontal sync, vertical sync, composite sync, a blanking signal, a pixel-active gate and a one-cycle frame-start event. Each axis is described by four programmable values: sync width, delay from the end of sync to the visible region, visible length, and total period. All four values are written as "count minus one", so a value of N spans N+1 pixel clocks on the horizontal axis or N+1 lines on the vertical axis.

Two counters track the position in the frame. The horizontal counter runs at the pixel clock. The vertical counter advances once per line. A decode stage turns the counter position into active-high timing signals and registers them. Each of the four sync and blank outputs then passes through its own polarity control. Pixel fetch logic waits while blank is asserted. Interrupt and bank-swap logic use the frame-start pulse. Clearing the enable input stops the raster and parks it at the top-left position.

Top module: `video_timing_gen`

## Requirements
- R1: While rst_n is low, the raw timing state is inactive: hSync=hSyncPol, vSync=vSyncPol, cSync=cSyncPol, blank=!blankPol, pixActive=0 and frameStart=0.
- R2: With enable high, a line lasts hTotal+1 clocks. Horizontal sync is active in the first hSyncLen+1 clocks of each line. Outputs appear one clock after the counter position they describe, and the first enabled cycle is pixel 0 of line 0.
- R3: The horizontal gate opens hSyncLen+hGateDly+2 clocks after the line start and stays open for hGateLen+1 clocks. The vertical gate is defined the same way in lines. pixActive is high only when both gates are open, and a gate that runs past the total is cut off by the wrap.
- R4: The line counter advances once per horizontal wrap and restarts after line vTotal. Vertical sync is active during the whole of the first vSyncLen+1 lines.
- R5: Before polarity is applied, blank is the inverse of pixActive.
- R6: Before polarity is applied, composite sync is the OR of the active-high horizontal and vertical syncs.
- R7: A polarity bit of 1 inverts its output (hSync, vSync, cSync, blank). The inversion is combinational, so it takes effect without waiting for a clock.
- R8: frameStart is a one-clock pulse in the first cycle of each frame. That cycle coincides with the leading edge of vertical sync.
- R9: When enable is sampled low, the counters return to zero. In the next cycle the outputs become inactive: no sync, blank asserted, gate closed and no frameStart, even if that edge would have started a frame. The first cycle after enable returns is a frame start.
- R10: A counter wraps whenever it is at or beyond its total. Lowering a total below the current position therefore restarts the axis on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the raster when high |
| hSyncLen | input | CNT_W | Horizontal sync width minus one |
| hGateDly | input | CNT_W | Horizontal sync-to-visible delay minus one |
| hGateLen | input | CNT_W | Visible pixels per line minus one |
| hTotal | input | CNT_W | Line period minus one |
| vSyncLen | input | CNT_W | Vertical sync width in lines minus one |
| vGateDly | input | CNT_W | Vertical sync-to-visible delay minus one |
| vGateLen | input | CNT_W | Visible lines minus one |
| vTotal | input | CNT_W | Frame period in lines minus one |
| hSyncPol | input | 1 | Invert horizontal sync when 1 |
| vSyncPol | input | 1 | Invert vertical sync when 1 |
| cSyncPol | input | 1 | Invert composite sync when 1 |
| blankPol | input | 1 | Invert blank when 1 |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| cSync | output | 1 | Composite sync |
| blank | output | 1 | High (before polarity) outside the visible region |
| pixActive | output | 1 | Visible-pixel gate, always active high |
| frameStart | output | 1 | One-clock pulse at the start of each frame |

## Verification
The frame-start pulse and a disable can fall on the same clock edge. This happens when enable drops in exactly the cycle in which the counters sit at pixel 0 of line 0. The bench steps an enabled raster until its own reference position returns to the frame origin, then clears enable before the next edge. It judges that the pulse is suppressed and that the outputs go inactive. It then re-enables and expects the pulse in the very first cycle. A second collision, a lowered total meeting a counter already past it, is provoked mid-line and judged against the reference position.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int NUM_AXES = 2;
  localparam int AXIS_H = 0;
  localparam int AXIS_V = 1;

  // strobes handed from counter control to the decode datapath
  typedef struct packed {
    logic run;        // raster enabled in this cycle
    logic frameHead;  // counters sit at pixel 0 of line 0
  } vtgStrobe_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] hTotal,
  input  logic [CNT_W-1:0] vTotal,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output vtgStrobe_t       strobe
);
  logic lineWrap;
  logic frameWrap;

  assign lineWrap  = (hCnt >= hTotal);
  assign frameWrap = (vCnt >= vTotal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!enable) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineWrap) begin
      hCnt <= '0;
      vCnt <= frameWrap ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.run       = enable;
    strobe.frameHead = enable && (hCnt == '0) && (vCnt == '0);
  end
endmodule

// File: rtl/vtg_axis_dec.sv
module vtg_axis_dec #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] syncLen,
  input  logic [CNT_W-1:0] gateDly,
  input  logic [CNT_W-1:0] gateLen,
  output logic             inSync,
  output logic             inGate
);
  localparam int EXT_W = CNT_W + 2;

  logic [EXT_W-1:0] gateFirst;
  logic [EXT_W-1:0] gateLast;
  logic [EXT_W-1:0] cntExt;

  always_comb begin
    cntExt    = EXT_W'(cnt);
    gateFirst = EXT_W'(syncLen) + EXT_W'(gateDly) + EXT_W'(2);
    gateLast  = gateFirst + EXT_W'(gateLen);
    inSync    = (cnt <= syncLen);
    inGate    = (cntExt >= gateFirst) && (cntExt <= gateLast);
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vtgStrobe_t       strobe,
  input  logic [CNT_W-1:0] hCnt,
  input  logic [CNT_W-1:0] vCnt,
  input  logic [CNT_W-1:0] hSyncLen,
  input  logic [CNT_W-1:0] hGateDly,
  input  logic [CNT_W-1:0] hGateLen,
  input  logic [CNT_W-1:0] vSyncLen,
  input  logic [CNT_W-1:0] vGateDly,
  input  logic [CNT_W-1:0] vGateLen,
  input  logic             hSyncPol,
  input  logic             vSyncPol,
  input  logic             cSyncPol,
  input  logic             blankPol,
  output logic             hSync,
  output logic             vSync,
  output logic             cSync,
  output logic             blank,
  output logic             pixActive,
  output logic             frameStart
);
  logic [CNT_W-1:0] axCnt     [NUM_AXES];
  logic [CNT_W-1:0] axSyncLen [NUM_AXES];
  logic [CNT_W-1:0] axGateDly [NUM_AXES];
  logic [CNT_W-1:0] axGateLen [NUM_AXES];
  logic             axSync    [NUM_AXES];
  logic             axGate    [NUM_AXES];

  assign axCnt[AXIS_H]     = hCnt;
  assign axCnt[AXIS_V]     = vCnt;
  assign axSyncLen[AXIS_H] = hSyncLen;
  assign axSyncLen[AXIS_V] = vSyncLen;
  assign axGateDly[AXIS_H] = hGateDly;
  assign axGateDly[AXIS_V] = vGateDly;
  assign axGateLen[AXIS_H] = hGateLen;
  assign axGateLen[AXIS_V] = vGateLen;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    vtg_axis_dec #(.CNT_W(CNT_W)) u_dec (
      .cnt     (axCnt[a]),
      .syncLen (axSyncLen[a]),
      .gateDly (axGateDly[a]),
      .gateLen (axGateLen[a]),
      .inSync  (axSync[a]),
      .inGate  (axGate[a])
    );
  end

  // raw active-high timing, registered
  logic hSyncRaw, vSyncRaw, cSyncRaw, blankRaw, gateRaw, headRaw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hSyncRaw <= 1'b0;
      vSyncRaw <= 1'b0;
      cSyncRaw <= 1'b0;
      blankRaw <= 1'b1;
      gateRaw  <= 1'b0;
      headRaw  <= 1'b0;
    end else if (!strobe.run) begin
      hSyncRaw <= 1'b0;
      vSyncRaw <= 1'b0;
      cSyncRaw <= 1'b0;
      blankRaw <= 1'b1;
      gateRaw  <= 1'b0;
      headRaw  <= 1'b0;
    end else begin
      hSyncRaw <= axSync[AXIS_H];
      vSyncRaw <= axSync[AXIS_V];
      cSyncRaw <= axSync[AXIS_H] | axSync[AXIS_V];
      blankRaw <= ~(axGate[AXIS_H] & axGate[AXIS_V]);
      gateRaw  <= axGate[AXIS_H] & axGate[AXIS_V];
      headRaw  <= strobe.frameHead;
    end
  end

  assign hSync      = hSyncRaw ^ hSyncPol;
  assign vSync      = vSyncRaw ^ vSyncPol;
  assign cSync      = cSyncRaw ^ cSyncPol;
  assign blank      = blankRaw ^ blankPol;
  assign pixActive  = gateRaw;
  assign frameStart = headRaw;
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] hSyncLen,
  input  logic [CNT_W-1:0] hGateDly,
  input  logic [CNT_W-1:0] hGateLen,
  input  logic [CNT_W-1:0] hTotal,
  input  logic [CNT_W-1:0] vSyncLen,
  input  logic [CNT_W-1:0] vGateDly,
  input  logic [CNT_W-1:0] vGateLen,
  input  logic [CNT_W-1:0] vTotal,
  input  logic             hSyncPol,
  input  logic             vSyncPol,
  input  logic             cSyncPol,
  input  logic             blankPol,
  output logic             hSync,
  output logic             vSync,
  output logic             cSync,
  output logic             blank,
  output logic             pixActive,
  output logic             frameStart
);
  logic [CNT_W-1:0] hCnt;
  logic [CNT_W-1:0] vCnt;
  vtgStrobe_t       strobe;

  vtg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .hTotal (hTotal),
    .vTotal (vTotal),
    .hCnt   (hCnt),
    .vCnt   (vCnt),
    .strobe (strobe)
  );

  vtg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .hCnt       (hCnt),
    .vCnt       (vCnt),
    .hSyncLen   (hSyncLen),
    .hGateDly   (hGateDly),
    .hGateLen   (hGateLen),
    .vSyncLen   (vSyncLen),
    .vGateDly   (vGateDly),
    .vGateLen   (vGateLen),
    .hSyncPol   (hSyncPol),
    .vSyncPol   (vSyncPol),
    .cSyncPol   (cSyncPol),
    .blankPol   (blankPol),
    .hSync      (hSync),
    .vSync      (vSync),
    .cSync      (cSync),
    .blank      (blank),
    .pixActive  (pixActive),
    .frameStart (frameStart)
  );
endmodule

// File: rtl/video_timing_gen_chk.sv
module video_timing_gen_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] hTotal,
  input logic [CNT_W-1:0] vTotal,
  input logic             hSyncPol,
  input logic             vSyncPol,
  input logic             cSyncPol,
  input logic             blankPol,
  input logic             hSync,
  input logic             vSync,
  input logic             cSync,
  input logic             blank,
  input logic             pixActive,
  input logic             frameStart
);
  assert_blank_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank ^ blankPol) == !pixActive);

  assert_csync_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cSync ^ cSyncPol) == ((hSync ^ hSyncPol) | (vSync ^ vSyncPol)));

  assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && (hTotal != '0 || vTotal != '0)) |=> !frameStart);

  assert_frame_in_vsync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> (vSync ^ vSyncPol));

  assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pixActive && !frameStart && !(hSync ^ hSyncPol)));
endmodule

bind video_timing_gen video_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .hTotal     (hTotal),
  .vTotal     (vTotal),
  .hSyncPol   (hSyncPol),
  .vSyncPol   (vSyncPol),
  .cSyncPol   (cSyncPol),
  .blankPol   (blankPol),
  .hSync      (hSync),
  .vSync      (vSync),
  .cSync      (cSync),
  .blank      (blank),
  .pixActive  (pixActive),
  .frameStart (frameStart)
);

// File: tb/test_video_timing_gen.sv
module test_video_timing_gen;
  localparam int CNT_W = 12;

  typedef struct packed {
    logic [11:0] hs, hd, hg, ht;
    logic [11:0] vs, vd, vg, vt;
    logic [3:0]  pol;      // {hSyncPol, vSyncPol, cSyncPol, blankPol}
    logic [15:0] cycles;
  } cfg_t;

  localparam int NCFG = 5;
  localparam cfg_t CFG [NCFG] = '{
    '{12'd1, 12'd1, 12'd3,   12'd10,  12'd0, 12'd0, 12'd2, 12'd5,  4'b0000, 16'd150},
    '{12'd1, 12'd1, 12'd3,   12'd10,  12'd0, 12'd0, 12'd2, 12'd5,  4'b1111, 16'd150},
    '{12'd0, 12'd0, 12'd0,   12'd2,   12'd0, 12'd0, 12'd0, 12'd0,  4'b0101, 16'd40},
    '{12'd2, 12'd3, 12'd20,  12'd12,  12'd1, 12'd1, 12'd9, 12'd7,  4'b1010, 16'd250},
    '{12'd6, 12'd20, 12'd319, 12'd390, 12'd1, 12'd2, 12'd5, 12'd12, 4'b0000, 16'd5200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CNT_W-1:0] hSyncLen = '0, hGateDly = '0, hGateLen = '0, hTotal = '0;
  logic [CNT_W-1:0] vSyncLen = '0, vGateDly = '0, vGateLen = '0, vTotal = '0;
  logic hSyncPol = 1'b0, vSyncPol = 1'b0, cSyncPol = 1'b0, blankPol = 1'b0;
  logic hSync, vSync, cSync, blank, pixActive, frameStart;

  always #2 clk = ~clk;

  video_timing_gen #(.CNT_W(CNT_W)) i_video_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hSyncLen(hSyncLen), .hGateDly(hGateDly), .hGateLen(hGateLen), .hTotal(hTotal),
    .vSyncLen(vSyncLen), .vGateDly(vGateDly), .vGateLen(vGateLen), .vTotal(vTotal),
    .hSyncPol(hSyncPol), .vSyncPol(vSyncPol), .cSyncPol(cSyncPol), .blankPol(blankPol),
    .hSync(hSync), .vSync(vSync), .cSync(cSync), .blank(blank),
    .pixActive(pixActive), .frameStart(frameStart)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string ctx = "";
  int mH = 0, mV = 0;
  logic [5:0] expRaw = 6'b000100; // {hs, vs, cs, blank, gate, frameStart}

  task automatic check(input logic act, input logic exp, input string req, input string name);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s %s: actual=%b expected=%b (mH=%0d mV=%0d t=%0t)",
               req, ctx, name, act, exp, mH, mV, $time);
    end
  endtask

  function automatic logic [5:0] reference();
    int hFirst, vFirst;
    logic hs, vs, hgt, vgt;
    if (!enable) return 6'b000100;
    hFirst = int'(hSyncLen) + int'(hGateDly) + 2;
    vFirst = int'(vSyncLen) + int'(vGateDly) + 2;
    hs  = (mH <= int'(hSyncLen));
    vs  = (mV <= int'(vSyncLen));
    hgt = (mH >= hFirst) && (mH <= hFirst + int'(hGateLen));
    vgt = (mV >= vFirst) && (mV <= vFirst + int'(vGateLen));
    return {hs, vs, hs | vs, !(hgt && vgt), hgt && vgt, (mH == 0) && (mV == 0)};
  endfunction

  task automatic advance();
    if (!enable) begin
      mH = 0; mV = 0;
    end else if (mH >= int'(hTotal)) begin
      mH = 0;
      mV = (mV >= int'(vTotal)) ? 0 : mV + 1;
    end else begin
      mH = mH + 1;
    end
  endtask

  task automatic compareAll();
    check(hSync,      expRaw[5] ^ hSyncPol,  "R2", "hSync");
    check(vSync,      expRaw[4] ^ vSyncPol,  "R4", "vSync");
    check(cSync,      expRaw[3] ^ cSyncPol,  "R6", "cSync");
    check(blank,      expRaw[2] ^ blankPol,  "R5", "blank");
    check(pixActive,  expRaw[1],             "R3", "pixActive");
    check(frameStart, expRaw[0],             "R8", "frameStart");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      expRaw = reference();
      advance();
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic loadCfg(input cfg_t c);
    hSyncLen = c.hs; hGateDly = c.hd; hGateLen = c.hg; hTotal = c.ht;
    vSyncLen = c.vs; vGateDly = c.vd; vGateLen = c.vg; vTotal = c.vt;
    {hSyncPol, vSyncPol, cSyncPol, blankPol} = c.pol;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    // R1: reset state with mixed polarities
    {hSyncPol, vSyncPol, cSyncPol, blankPol} = 4'b1010;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    ctx = "R1";
    check(hSync, 1'b1, "R1", "hSync");
    check(vSync, 1'b0, "R1", "vSync");
    check(cSync, 1'b1, "R1", "cSync");
    check(blank, 1'b1, "R1", "blank");
    check(pixActive, 1'b0, "R1", "pixActive");
    check(frameStart, 1'b0, "R1", "frameStart");
    enable = 1'b0;
    rst_n = 1'b1;
    mH = 0; mV = 0;

    // vector table walk: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NCFG; k++) begin
      ctx = $sformatf("cfg%0d", k);
      enable = 1'b0;
      loadCfg(CFG[k]);
      step(2);
      enable = 1'b1;
      step(int'(CFG[k].cycles));
    end

    // R7: polarity flip takes effect without a clock edge
    ctx = "R7";
    loadCfg(CFG[0]);
    step(20);
    {hSyncPol, vSyncPol, cSyncPol, blankPol} = 4'b1111;
    #1;
    check(hSync, expRaw[5] ^ 1'b1, "R7", "hSync");
    check(vSync, expRaw[4] ^ 1'b1, "R7", "vSync");
    check(cSync, expRaw[3] ^ 1'b1, "R7", "cSync");
    check(blank, expRaw[2] ^ 1'b1, "R7", "blank");
    step(10);

    // R9: disable lands exactly on the frame-start edge
    ctx = "R9";
    step(1);
    while (!(mH == 0 && mV == 0)) step(1);
    enable = 1'b0;
    step(1);
    check(frameStart, 1'b0, "R9", "frameStart suppressed");
    check(pixActive, 1'b0, "R9", "pixActive off");
    check(blank, ~blankPol, "R9", "blank on");
    step(3);
    enable = 1'b1;
    step(1);
    check(frameStart, 1'b1, "R9", "frameStart on re-enable");
    step(30);

    // R10: total lowered below the current position
    ctx = "R10";
    while (mH != 8) step(1);
    hTotal = 12'd4;
    step(1);
    step(1);
    check(hSync, 1'b1 ^ hSyncPol, "R10", "hSync after forced wrap");
    step(40);

    finish();
  end
endmodule